// File: doc/BRIEF.md
# Prescaled Down-Counting Interval Timer

This block is an interval timer for a small microcontroller subsystem. An 8-bit down-counter is stepped by the carry of a 7-stage binary prescaler, and the prescaler is in turn stepped by one of four selectable sources. These are the internal phase clock (a per-cycle clock enable), that clock qualified by the level of an external timer pin, the rising edges of that pin alone, or nothing at all. When the count steps down to zero, a sticky request flag is raised. A level-sensitive interrupt line follows that flag unless software masks it.

Software reaches the timer through a byte-wide register port with two locations. Location 0 holds the count: a read returns the live value without disturbing it, and a write loads it. Location 1 holds the control byte. Its bit 7 is the request flag and bit 6 is the mask. Bits 5:4 pick the source: 00 internal, 01 internal gated by the pin, 10 stopped, 11 pin edges. Bit 3 is a write-only prescaler clear. Bits 2:0 select a division of 2 to the power of the field. The counter is decremented once every 2^field source ticks and keeps running through zero, wrapping to 0xFF.

Top module: `itmr_top`

## Requirements
- R1: After reset, location 1 reads 0x70 (request 0, mask 1, source 11, prescale 000), location 0 reads 0xFF, irq is low, and the prescaler holds all ones.
- R2: With source 00 and a control write that sets bit 3 and selects prescale field s, a count of N reaches zero and raises the request exactly N·2^s clock cycles after that write's clock edge.
- R3: Writing 1 to control bit 3 clears the prescaler for one cycle. Bit 3 always reads back as 0.
- R4: With source 10, or with clk_en low while source 00 or 01 is selected, the count does not change.
- R5: With source 01, the count advances only while the synchronised pin is high. The pin passes two flops, so a pin held high for H cycles yields H decrements at prescale 0.
- R6: With source 11, each rising edge of the synchronised pin gives one prescaler tick, independently of clk_en.
- R7: The request bit (control bit 7) is set when a decrement takes the count from 1 to 0. It stays set until software writes 0 to bit 7. Writing 1 to bit 7 has no effect.
- R8: irq is high exactly while the request bit is 1 and the mask bit (control bit 6) is 0. A masked request can be cleared without irq rising.
- R9: A decrement from 0 gives 0xFF. A write to location 0 loads the count and takes priority over a decrement in the same cycle.
- R10: When a decrement to zero and a software write of 0 to bit 7 fall in the same cycle, the request ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Internal phase clock enable, one tick per high cycle |
| addr | input | 1 | Register select: 0 count, 1 control |
| wr_en | input | 1 | Write strobe for the selected register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register (combinational) |
| tmr_pin | input | 1 | External timer pin, asynchronous |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that tmr_pin may change at any time but that only its synchronised copy matters. They also assume that a register write lasts one cycle, with address and data stable around the edge. The bench drives every bus input at the falling edge and holds each pin level for several cycles, so each intended edge is seen once. Where a source change and a prescaler clear share a write, the old source governs that edge. The timing sweeps therefore stop the counter before loading it, which keeps the starting point of each measurement exact.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

  typedef enum logic [1:0] {
    SRC_INT   = 2'b00,
    SRC_GATED = 2'b01,
    SRC_OFF   = 2'b10,
    SRC_PIN   = 2'b11
  } src_e;

  localparam int REQ_BIT = 7;
  localparam int MSK_BIT = 6;
  localparam int SRC_HI  = 5;
  localparam int SRC_LO  = 4;
  localparam int CLR_BIT = 3;

  // one prescaler input tick for the chosen source
  function automatic logic take_tick(input src_e m, input logic en,
                                     input logic lvl, input logic rise);
    case (m)
      SRC_INT:   return en;
      SRC_GATED: return en & lvl;
      SRC_PIN:   return rise;
      default:   return 1'b0;
    endcase
  endfunction

  // carry out of the low sel stages: all of them are ones
  function automatic logic stage_due(input logic [31:0] pre, input logic [31:0] sel);
    logic [31:0] m;
    m = (32'd1 << sel) - 32'd1;
    return (pre & m) == m;
  endfunction

endpackage

// File: rtl/itmr_sync.sv
module itmr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync,
  output logic q_rise
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], d_async};
      last  <= chain[STAGES-1];
    end
  end

  assign q_sync = chain[STAGES-1];
  assign q_rise = chain[STAGES-1] & ~last;
endmodule

// File: rtl/itmr_prescaler.sv
module itmr_prescaler
  import itmr_pkg::*;
#(
  parameter int PRE_W = 7,
  localparam int SEL_W = $clog2(PRE_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             step,
  output logic [PRE_W-1:0] pre_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    pre_q <= '1;
    else if (clr)  pre_q <= '0;
    else if (tick) pre_q <= pre_q + 1'b1;
  end

  assign step = tick & ~clr & stage_due(32'(pre_q), 32'(sel));
endmodule

// File: rtl/itmr_counter.sv
module itmr_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             zero_hit
);
  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '1;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_hit = dec & ~load & (cnt_q == CNT_W'(1));
endmodule

// File: rtl/itmr_top.sv
module itmr_top
  import itmr_pkg::*;
#(
  parameter int PRE_W  = 7,
  parameter int SYNC_N = 2,
  localparam int SEL_W = $clog2(PRE_W + 1),
  localparam int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_en,
  input  logic          addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          tmr_pin,
  output logic          irq
);
  logic             req_q, mask_q;
  src_e             src_q;
  logic [SEL_W-1:0] sel_q;
  logic             pin_s, pin_rise;
  logic             tick, step, zero_hit;
  logic             wr_cnt, wr_ctl, psc_clr;
  logic [PRE_W-1:0] pre_q;
  logic [DW-1:0]    cnt_q;

  assign wr_cnt  = wr_en & ~addr;
  assign wr_ctl  = wr_en & addr;
  assign psc_clr = wr_ctl & wdata[CLR_BIT];

  itmr_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(tmr_pin),
    .q_sync(pin_s), .q_rise(pin_rise)
  );

  assign tick = take_tick(src_q, clk_en, pin_s, pin_rise);

  itmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr(psc_clr),
    .sel(sel_q), .step(step), .pre_q(pre_q)
  );

  itmr_counter #(.CNT_W(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .dec(step), .load(wr_cnt),
    .load_val(wdata), .cnt_q(cnt_q), .zero_hit(zero_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      mask_q <= 1'b1;
      src_q  <= SRC_PIN;
      sel_q  <= '0;
    end else begin
      if (wr_ctl) begin
        mask_q <= wdata[MSK_BIT];
        src_q  <= src_e'(wdata[SRC_HI:SRC_LO]);
        sel_q  <= wdata[SEL_W-1:0];
      end
      // hardware set wins over a software clear
      if (zero_hit)                         req_q <= 1'b1;
      else if (wr_ctl && !wdata[REQ_BIT])   req_q <= 1'b0;
    end
  end

  always_comb begin
    if (addr) rdata = {req_q, mask_q, src_q, 1'b0, sel_q};
    else      rdata = cnt_q;
  end

  assign irq = req_q & ~mask_q;
endmodule

// File: rtl/itmr_checker.sv
module itmr_checker #(
  parameter int PRE_W = 7,
  parameter int DW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_cnt,
  input logic             wr_ctl,
  input logic [DW-1:0]    wdata,
  input logic             psc_clr,
  input logic             step,
  input logic             zero_hit,
  input logic             req_q,
  input logic [1:0]       src_q,
  input logic [PRE_W-1:0] pre_q,
  input logic [DW-1:0]    cnt_q
);
  assert_clr_zeroes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    psc_clr |=> (pre_q == '0));

  assert_off_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q == 2'b10 && !wr_cnt) |=> $stable(cnt_q));

  assert_zero_sets_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    zero_hit |=> req_q);

  assert_req_rise_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> $past(zero_hit));

  assert_step_decrements_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_cnt) |=> (cnt_q == $past(cnt_q) - 1'b1));

  assert_set_beats_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_hit && wr_ctl && !wdata[7]) |=> req_q);
endmodule

bind itmr_top itmr_checker #(.PRE_W(PRE_W), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_cnt(wr_cnt), .wr_ctl(wr_ctl), .wdata(wdata),
  .psc_clr(psc_clr), .step(step), .zero_hit(zero_hit), .req_q(req_q),
  .src_q(src_q), .pre_q(pre_q), .cnt_q(cnt_q)
);

// File: tb/itmr_top_bench.sv
module itmr_top_bench;
  logic       clk = 0, rst_n = 0, clk_en = 1, addr = 0, wr_en = 0, tmr_pin = 0;
  logic [7:0] wdata = 0, rdata;
  logic       irq;
  int         n_run = 0, n_bad = 0;
  bit         done = 0;

  itmr_top u_itmr_top (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .tmr_pin(tmr_pin), .irq(irq)
  );

  always #4 clk = ~clk;

  function automatic logic [7:0] ctl(input logic req, input logic msk,
                                     input logic [1:0] src, input logic clr,
                                     input logic [2:0] ps);
    return {req, msk, src, clr, ps};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1_600_000;
    if (!done) begin
      n_bad++; n_run++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    idle(3);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(1, v); chk("R1 ctrl", v, 8'h70);
    rd(0, v); chk("R1 count", v, 8'hFF);
    chk("R1 irq", {7'd0, irq}, 8'd0);

    // R2/R3 sweep of prescale field and count
    for (int s = 0; s < 8; s++) begin
      for (int n = 1; n <= 3; n++) begin
        int k;
        wr(1, ctl(0, 1, 2'b10, 0, 3'd0));
        wr(0, 8'(n));
        wr(1, ctl(0, 1, 2'b00, 1, 3'(s)));
        k = 0;
        rd(1, v);
        while (!v[7] && k < 2000) begin
          @(negedge clk); k++; rd(1, v);
        end
        chk($sformatf("R2 s=%0d n=%0d cycles", s, n), 8'(k >> s), 8'(n));
        chk($sformatf("R2 s=%0d n=%0d low", s, n), 8'(k & ((1 << s) - 1)), 8'd0);
        chk("R3 clr reads 0", {7'd0, v[3]}, 8'd0);
      end
    end

    // R4 stopped source and clock enable low
    wr(1, ctl(0, 1, 2'b10, 0, 3'd0));
    wr(0, 8'd40);
    idle(10); rd(0, v); chk("R4 stopped", v, 8'd40);
    clk_en = 0;
    wr(1, ctl(0, 1, 2'b00, 0, 3'd0));
    idle(10); rd(0, v); chk("R4 clk_en low", v, 8'd40);
    clk_en = 1;
    idle(5); rd(0, v); chk("R4 resumes", v, 8'd35);

    // R5 gated source
    wr(1, ctl(0, 1, 2'b10, 0, 3'd0));
    wr(0, 8'd100);
    wr(1, ctl(0, 1, 2'b01, 1, 3'd0));
    idle(10); rd(0, v); chk("R5 pin low", v, 8'd100);
    tmr_pin = 1; idle(10); tmr_pin = 0; idle(6);
    rd(0, v); chk("R5 pin high 10", v, 8'd90);

    // R6 pin edges, clk_en low
    wr(1, ctl(0, 1, 2'b11, 1, 3'd0));
    wr(0, 8'd50);
    clk_en = 0;
    for (int p = 0; p < 5; p++) begin
      tmr_pin = 1; idle(4); tmr_pin = 0; idle(4);
    end
    idle(4); rd(0, v); chk("R6 five edges", v, 8'd45);
    clk_en = 1;
    wr(1, ctl(0, 1, 2'b11, 1, 3'd1));
    for (int p = 0; p < 6; p++) begin
      tmr_pin = 1; idle(3); tmr_pin = 0; idle(3);
    end
    idle(4); rd(0, v); chk("R6 six edges div2", v, 8'd42);

    // R9 wrap and R7 sticky request
    wr(1, ctl(0, 1, 2'b10, 0, 3'd0));
    wr(0, 8'd2);
    wr(1, ctl(0, 1, 2'b00, 1, 3'd0));
    rd(0, v); chk("R9 no step at write", v, 8'd2);
    idle(3); rd(0, v); chk("R9 wrap", v, 8'hFF);
    wr(1, ctl(1, 1, 2'b10, 0, 3'd0));
    rd(1, v); chk("R7 write 1 keeps", {7'd0, v[7]}, 8'd1);
    idle(3); rd(1, v); chk("R7 sticky", {7'd0, v[7]}, 8'd1);
    // R8 mask
    chk("R8 masked irq", {7'd0, irq}, 8'd0);
    wr(1, ctl(1, 0, 2'b10, 0, 3'd0));
    #1 chk("R8 unmasked irq", {7'd0, irq}, 8'd1);
    wr(1, ctl(0, 0, 2'b10, 0, 3'd0));
    #1 chk("R7 clear", {7'd0, irq}, 8'd0);
    rd(1, v); chk("R7 clear bit", {7'd0, v[7]}, 8'd0);
    wr(1, ctl(1, 1, 2'b10, 0, 3'd0));
    wr(1, ctl(0, 1, 2'b10, 0, 3'd0));
    chk("R8 masked clear", {7'd0, irq}, 8'd0);
    // R9 load beats step
    wr(1, ctl(0, 1, 2'b00, 0, 3'd0));
    wr(0, 8'h80);
    rd(0, v); chk("R9 load wins", v, 8'h80);

    // R10 set beats clear in the same cycle
    wr(1, ctl(0, 1, 2'b10, 0, 3'd0));
    wr(0, 8'd2);
    wr(1, ctl(0, 1, 2'b00, 1, 3'd0));
    wr(1, ctl(0, 1, 2'b10, 0, 3'd0));
    rd(1, v); chk("R10 set wins", {7'd0, v[7]}, 8'd1);
    rd(0, v); chk("R10 count zero", v, 8'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule